// File: doc/BRIEF.md
# SPI Master Frame Sequencer with Held Chip Select

This block is an SPI master that works through a stream of transfer commands. Each command carries the data to send, the frame length, which chip-select lines to drive, a hold-select flag, a clock phase and a clock polarity. For every frame the block drives the chip-select lines, the serial clock and the serial output. It samples the serial input and returns the received word with a one-cycle valid strobe. Three delays are programmable in system clocks: select-to-first-clock, last-clock-to-release and the minimum released time between frames. The half period of the serial clock is also programmable.

Some frames have the hold-select flag set and are followed by a queued command that drives the same lines. In that case the chip selects stay driven across both frames and the release gap is skipped. The select-to-clock and clock-to-release delays still separate the two clock bursts. In every other case the lines return to their configured idle levels and stay there for the release gap.

Top module: `spi_cs_master`

## Requirements
- R1: Synchronous active-low reset leaves `pcs_o` equal to `cfg_cs_idle`, `sck_o` low, `sout_o` low, `cmd_ready_o` high and `rx_valid_o` low.
- R2: In the idle state `cmd_ready_o` is high. A command with `cmd_valid_i` high is taken at that clock edge. In the next cycle `pcs_o` equals `cfg_cs_idle ^ cmd_cs_i`, so a 1 in `cmd_cs_i` drives that line to the inverse of its idle bit. `sck_o` equals `cmd_cpol_i` in the same cycle.
- R3: A frame has N = `cmd_len_i`+1 bits (1 to MAXB; 4-bit frames included) and exactly 2N SCK edges. The first edge appears `cfg_lead` cycles after the frame starts. Each later edge appears `cfg_half` cycles after the previous one.
- R4: SCK rests at the frame's polarity bit before the first edge and returns to it on the last edge. The chip-select timing is the same for either polarity.
- R5: Data leaves MSB first (bit N-1 of `cmd_data_i`). From frame start until the first edge `sout_o` shows the MSB. With phase 0 the next bit appears on each trailing (odd-numbered, counting from 0) edge except the last. With phase 1 the next bit appears on each leading edge after the first.
- R6: `sin_i` is sampled on leading edges with phase 0 and on trailing edges with phase 1. `rx_valid_o` pulses for one cycle, in the cycle the last edge appears. `rx_data_o` then holds the N samples right-aligned, with the first sample at bit N-1 and zeros above.
- R7: `cfg_trail` cycles after the last edge the block either releases the selects or starts the next held frame.
- R8: When a frame is not held, `pcs_o` returns to `cfg_cs_idle` and stays there `cfg_gap` cycles. The block is then idle, so a waiting command re-drives the selects `cfg_gap`+1 cycles after release.
- R9: When the hold flag is set and the command presented at the end of the release delay has the same `cmd_cs_i`, that command is taken in that cycle with `cmd_ready_o` high. `pcs_o` does not change, no gap is inserted, and the next first edge follows the previous last edge by `cfg_trail`+`cfg_lead` cycles.
- R10: A set hold flag with a differing select vector, or with no command waiting, releases and gaps exactly as in R8.
- R11: A delay or half-period setting of 0 acts as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cs_idle | input | NCS | Idle level of each select line |
| cfg_half | input | DW | SCK half period in cycles |
| cfg_lead | input | DW | Select-to-first-edge delay |
| cfg_trail | input | DW | Last-edge-to-release delay |
| cfg_gap | input | DW | Minimum released time between frames |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command taken at this edge when valid |
| cmd_data_i | input | MAXB | Transmit word, right-aligned |
| cmd_len_i | input | LW | Frame length minus one |
| cmd_cs_i | input | NCS | Lines to drive (1 = drive) |
| cmd_hold_i | input | 1 | Keep selects driven into a matching next frame |
| cmd_cpha_i | input | 1 | Clock phase |
| cmd_cpol_i | input | 1 | Clock polarity |
| sck_o | output | 1 | Serial clock |
| sout_o | output | 1 | Serial data out |
| sin_i | input | 1 | Serial data in |
| pcs_o | output | NCS | Chip-select lines |
| rx_valid_o | output | 1 | Received word strobe |
| rx_data_o | output | MAXB | Received word |

## Verification
A corrupted edge counter shows up at `sck_o` within one half period, as a missing or extra edge and a misplaced `rx_valid_o`. A wrong bit pointer corrupts `sout_o` on the next shifting edge. A wrong latched select vector or hold flag is visible on `pcs_o`, or through `cmd_ready_o`, at the end of the release delay, when the hold decision is made. A timer fault moves an edge, a release or a ready by whole cycles. Because the bench compares every output every cycle, the first bad cycle is the one reported.

// File: rtl/spi_cm_pkg.sv
// Shared types for the SPI master frame sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package spi_cm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // selects released, waiting for a command
        ST_LEAD  = 3'd1,   // selects driven, counting select-to-clock delay
        ST_SHIFT = 3'd2,   // producing SCK edges
        ST_TRAIL = 3'd3,   // after last edge, counting release delay
        ST_GAP   = 3'd4    // selects released, counting minimum gap
    } spi_st_e;
endpackage

// File: rtl/spi_cm_timer.sv
// Down counter for delays and half periods.
// A load of value V makes zero_o rise V-1 cycles later, so the phase it
// times lasts V cycles. V = 0 is treated as 1. Assumes load is a pulse.
module spi_cm_timer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] val,
    output logic          zero_o
);
    logic [DW-1:0] cnt_q;

    // Count down from the loaded value and saturate at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (val == '0) ? '0 : val - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R11: a load of 0 or 1 gives a one-cycle phase.
    p_zero_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load && val <= 1) |=> zero_o);
endmodule

// File: rtl/spi_cm_shifter.sv
// Transmit bit pointer and receive shift register for one frame.
// Assumes ld_len < MAXB and that fire never coincides with load.
// idx is the number of the edge being produced; even numbers are leading edges.
module spi_cm_shifter #(
    parameter int MAXB = 16,
    parameter int LW   = $clog2(MAXB),
    parameter int EW   = LW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MAXB-1:0] ld_data,
    input  logic [LW-1:0]   ld_len,
    input  logic            cpha,
    input  logic            fire,
    input  logic [EW-1:0]   idx,
    input  logic            last,
    input  logic            sin,
    output logic            sout,
    output logic [MAXB-1:0] rx
);
    logic [MAXB-1:0] tx_q;
    logic [LW-1:0]   ptr_q;
    logic            lead;
    logic            step;
    logic            grab;
    logic            msb_in;

    // Decide whether this edge moves the output bit and whether it samples.
    always_comb begin
        lead   = ~idx[0];
        step   = cpha ? (lead && idx != '0) : (!lead && !last);
        grab   = cpha ? !lead : lead;
        msb_in = ld_data[ld_len];
    end

    // Load a new frame, then move the pointer and sample on the chosen edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= '0;
            ptr_q <= '0;
            rx    <= '0;
        end else if (load) begin
            tx_q  <= ld_data;
            ptr_q <= ld_len;
            rx    <= '0;
        end else if (fire) begin
            if (step)
                ptr_q <= ptr_q - 1'b1;
            if (grab)
                rx <= {rx[MAXB-2:0], sin};
        end
    end

    assign sout = tx_q[ptr_q];

    // R5: the first bit presented after a load is the frame's MSB.
    p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sout == $past(msb_in)));
endmodule

// File: rtl/spi_cs_master.sv
// SPI master frame sequencer with optional held chip select.
// Takes one command at a time. It drives the selects, produces 2N SCK edges
// at cfg_half spacing after cfg_lead cycles, waits cfg_trail cycles, then
// either chains a matching held frame or releases for cfg_gap cycles.
// Assumes the cfg_* inputs change only while the block is idle.
module spi_cs_master
    import spi_cm_pkg::*;
#(
    parameter int NCS  = 4,
    parameter int MAXB = 16,
    parameter int DW   = 8,
    localparam int LW  = $clog2(MAXB),
    localparam int EW  = LW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCS-1:0]  cfg_cs_idle,
    input  logic [DW-1:0]   cfg_half,
    input  logic [DW-1:0]   cfg_lead,
    input  logic [DW-1:0]   cfg_trail,
    input  logic [DW-1:0]   cfg_gap,
    input  logic            cmd_valid_i,
    output logic            cmd_ready_o,
    input  logic [MAXB-1:0] cmd_data_i,
    input  logic [LW-1:0]   cmd_len_i,
    input  logic [NCS-1:0]  cmd_cs_i,
    input  logic            cmd_hold_i,
    input  logic            cmd_cpha_i,
    input  logic            cmd_cpol_i,
    output logic            sck_o,
    output logic            sout_o,
    input  logic            sin_i,
    output logic [NCS-1:0]  pcs_o,
    output logic            rx_valid_o,
    output logic [MAXB-1:0] rx_data_o
);
    spi_st_e        st_q;
    logic           cs_on_q;
    logic [NCS-1:0] cur_cs_q;
    logic           hold_q;
    logic           cpha_q;
    logic           cpol_q;
    logic           sck_q;
    logic [LW-1:0]  len_q;
    logic [EW-1:0]  edge_q;
    logic           rxv_q;

    logic           tmr_zero;
    logic           tmr_ld;
    logic [DW-1:0]  tmr_val;
    logic           take;
    logic           edge_fire;
    logic [EW-1:0]  edge_idx;
    logic           last_edge;
    logic           chain_ok;

    // Handshake, edge generation and the timer reload source.
    always_comb begin
        chain_ok    = (st_q == ST_TRAIL) && tmr_zero && hold_q && (cmd_cs_i == cur_cs_q);
        cmd_ready_o = (st_q == ST_IDLE) || chain_ok;
        take        = cmd_valid_i && cmd_ready_o;
        edge_fire   = (st_q == ST_LEAD || st_q == ST_SHIFT) && tmr_zero;
        edge_idx    = (st_q == ST_LEAD) ? '0 : edge_q + 1'b1;
        last_edge   = edge_fire && (edge_idx == {len_q, 1'b1});
        tmr_ld      = 1'b0;
        tmr_val     = cfg_half;
        if (take) begin
            tmr_ld  = 1'b1;
            tmr_val = cfg_lead;
        end else if (edge_fire) begin
            tmr_ld  = 1'b1;
            tmr_val = last_edge ? cfg_trail : cfg_half;
        end else if (st_q == ST_TRAIL && tmr_zero) begin
            tmr_ld  = 1'b1;
            tmr_val = cfg_gap;
        end
    end

    // Phase sequencing, select latch and SCK toggling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cs_on_q  <= 1'b0;
            cur_cs_q <= '0;
            hold_q   <= 1'b0;
            cpha_q   <= 1'b0;
            cpol_q   <= 1'b0;
            sck_q    <= 1'b0;
            len_q    <= '0;
            edge_q   <= '0;
            rxv_q    <= 1'b0;
        end else begin
            rxv_q <= last_edge;
            if (take) begin
                st_q     <= ST_LEAD;
                cs_on_q  <= 1'b1;
                cur_cs_q <= cmd_cs_i;
                hold_q   <= cmd_hold_i;
                cpha_q   <= cmd_cpha_i;
                cpol_q   <= cmd_cpol_i;
                sck_q    <= cmd_cpol_i;
                len_q    <= cmd_len_i;
                edge_q   <= '0;
            end else if (edge_fire) begin
                sck_q  <= ~sck_q;
                edge_q <= edge_idx;
                st_q   <= last_edge ? ST_TRAIL : ST_SHIFT;
            end else if (st_q == ST_TRAIL && tmr_zero) begin
                st_q    <= ST_GAP;
                cs_on_q <= 1'b0;
            end else if (st_q == ST_GAP && tmr_zero) begin
                st_q <= ST_IDLE;
            end
        end
    end

    spi_cm_timer #(.DW(DW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_ld),
        .val    (tmr_val),
        .zero_o (tmr_zero)
    );

    spi_cm_shifter #(.MAXB(MAXB), .LW(LW), .EW(EW)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take),
        .ld_data (cmd_data_i),
        .ld_len  (cmd_len_i),
        .cpha    (cpha_q),
        .fire    (edge_fire),
        .idx     (edge_idx),
        .last    (last_edge),
        .sin     (sin_i),
        .sout    (sout_o),
        .rx      (rx_data_o)
    );

    assign pcs_o      = cfg_cs_idle ^ (cs_on_q ? cur_cs_q : '0);
    assign sck_o      = sck_q;
    assign rx_valid_o = rxv_q;

    // R8: during the release gap every line sits at its idle level.
    p_gap_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GAP) |-> (pcs_o == cfg_cs_idle));
    // R9: a chained take keeps the selects unchanged and skips the gap.
    p_chain_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q == ST_TRAIL) |=> ($stable(pcs_o) && st_q == ST_LEAD));
    // R6: the receive strobe lasts one cycle.
    p_rx_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);
    // R4: the last edge returns SCK to its rest level.
    p_sck_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (sck_o == cpol_q));
    // R3: no SCK edge during the select-to-clock delay.
    p_lead_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LEAD && !tmr_zero) |=> $stable(sck_o));
endmodule

// File: tb/sim_spi_cs_master.sv
// Bench: a behavioural, time-scheduled model of the sequencer, compared on every clock.
module sim_spi_cs_master;
    localparam int NCS = 4, MAXB = 16, DW = 8, LW = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic            rst_n = 1'b0;
    logic [NCS-1:0]  cfg_cs_idle = '0;
    logic [DW-1:0]   cfg_half = 8'd2, cfg_lead = 8'd2, cfg_trail = 8'd2, cfg_gap = 8'd3;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [MAXB-1:0] cmd_data = '0;
    logic [LW-1:0]   cmd_len = '0;
    logic [NCS-1:0]  cmd_cs = '0;
    logic            cmd_hold = 1'b0, cmd_cpha = 1'b0, cmd_cpol = 1'b0;
    logic            sck, sout, sin = 1'b0;
    logic [NCS-1:0]  pcs;
    logic            rx_valid;
    logic [MAXB-1:0] rx_data;

    spi_cs_master #(.NCS(NCS), .MAXB(MAXB), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cs_idle(cfg_cs_idle),
        .cfg_half(cfg_half), .cfg_lead(cfg_lead), .cfg_trail(cfg_trail), .cfg_gap(cfg_gap),
        .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_data_i(cmd_data),
        .cmd_len_i(cmd_len), .cmd_cs_i(cmd_cs), .cmd_hold_i(cmd_hold),
        .cmd_cpha_i(cmd_cpha), .cmd_cpol_i(cmd_cpol),
        .sck_o(sck), .sout_o(sout), .sin_i(sin), .pcs_o(pcs),
        .rx_valid_o(rx_valid), .rx_data_o(rx_data)
    );

    typedef struct {
        logic [MAXB-1:0] d;
        int              n;
        logic [NCS-1:0]  cs;
        bit              hold, cpha, cpol;
    } cmd_t;
    cmd_t q[$];

    int n_cmp = 0, n_bad = 0, wd = 0;
    string tag = "R1";
    bit fire = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Model state.
    int mode = 0, cyc = 0, fs = 0, negt = 0, m_n = 1;
    logic [NCS-1:0]  m_cs = '0;
    logic [MAXB-1:0] m_data = '0, m_rx = '0;
    bit m_hold = 0, m_cpha = 0, m_cpol = 0, m_sout = 0;

    function automatic int dly(input logic [DW-1:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction
    function automatic int first_edge();
        return fs + dly(cfg_lead);
    endfunction
    function automatic int last_edge_t();
        return first_edge() + (2 * m_n - 1) * dly(cfg_half);
    endfunction
    function automatic int edges_done(input int c);
        int e;
        if (c < first_edge()) return 0;
        e = (c - first_edge()) / dly(cfg_half) + 1;
        return (e > 2 * m_n) ? 2 * m_n : e;
    endfunction

    task automatic m_load();
        m_cs = cmd_cs; m_hold = cmd_hold; m_cpha = cmd_cpha; m_cpol = cmd_cpol;
        m_n = int'(cmd_len) + 1; m_data = cmd_data; fs = cyc; mode = 1; m_rx = '0;
    endtask

    // Model step: decide phase changes and sample SIN on the scheduled edges.
    always @(posedge clk) begin
        if (!rst_n) begin
            mode = 0; cyc = 0; m_cpol = 0; m_sout = 0; m_rx = '0;
        end else begin
            cyc++;
            if (mode == 0) begin
                if (cmd_valid) m_load();
            end else if (mode == 1) begin
                if (cyc == last_edge_t() + dly(cfg_trail)) begin
                    if (m_hold && cmd_valid && cmd_cs == m_cs) m_load();
                    else begin mode = 2; negt = cyc; end
                end else if (cyc >= first_edge() && (cyc - first_edge()) % dly(cfg_half) == 0) begin
                    int k;
                    k = (cyc - first_edge()) / dly(cfg_half);
                    if (k < 2 * m_n && ((k % 2) == 1) == m_cpha)
                        m_rx = {m_rx[MAXB-2:0], sin};
                end
            end else if (mode == 2) begin
                if (cyc == negt + dly(cfg_gap)) mode = 0;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    // Drive inputs after the falling edge, then compare every output with the model.
    always @(negedge clk) begin
        if (fire) void'(q.pop_front());
        if (q.size() > 0) begin
            cmd_valid = 1'b1; cmd_data = q[0].d; cmd_len = LW'(q[0].n - 1);
            cmd_cs = q[0].cs; cmd_hold = q[0].hold; cmd_cpha = q[0].cpha; cmd_cpol = q[0].cpol;
        end else begin
            cmd_valid = 1'b0;
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sin = lfsr[0];
        #1;
        if (rst_n && !done) begin
            int e, idx;
            bit exp_sck, exp_rdy;
            e = (mode == 1) ? edges_done(cyc) : 0;
            exp_sck = (mode == 1) ? (m_cpol ^ e[0]) : m_cpol;
            if (mode == 1) begin
                if (!m_cpha) idx = m_n - 1 - (((e / 2) > m_n - 1) ? m_n - 1 : e / 2);
                else idx = m_n - 1 - ((e > 0) ? (e - 1) / 2 : 0);
                m_sout = m_data[idx];
            end
            exp_rdy = (mode == 0) ||
                      (mode == 1 && cyc == last_edge_t() + dly(cfg_trail) - 1 && m_hold && cmd_cs == m_cs);
            chk("pcs", 32'(pcs), 32'((mode == 1) ? (cfg_cs_idle ^ m_cs) : cfg_cs_idle));
            chk("sck", 32'(sck), 32'(exp_sck));
            chk("sout", 32'(sout), 32'(m_sout));
            chk("ready", 32'(cmd_ready), 32'(exp_rdy));
            chk("rx_valid", 32'(rx_valid), 32'(mode == 1 && cyc == last_edge_t()));
            if (mode == 1 && cyc == last_edge_t()) chk("rx_data", 32'(rx_data), 32'(m_rx));
        end
        fire = cmd_valid && cmd_ready && rst_n;
    end

    task automatic push(input logic [MAXB-1:0] d, input int n, input logic [NCS-1:0] cs,
                        input bit hold, input bit cpha, input bit cpol);
        cmd_t c;
        c.d = d; c.n = n; c.cs = cs; c.hold = hold; c.cpha = cpha; c.cpol = cpol;
        @(posedge clk);
        q.push_back(c);
    endtask

    task automatic setcfg(input logic [NCS-1:0] idl, input int h, input int l, input int t, input int g);
        @(posedge clk);
        cfg_cs_idle = idl; cfg_half = DW'(h); cfg_lead = DW'(l); cfg_trail = DW'(t); cfg_gap = DW'(g);
    endtask

    task automatic drain();
        @(posedge clk);
        while (q.size() != 0 || mode != 0) @(posedge clk);
        repeat (6) @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R1: reset state at the ports.
        chk("R1 pcs", 32'(pcs), 32'(cfg_cs_idle));
        chk("R1 sck", 32'(sck), 0);
        chk("R1 sout", 32'(sout), 0);
        chk("R1 ready", 32'(cmd_ready), 1);
        chk("R1 rx_valid", 32'(rx_valid), 0);

        tag = "R2";   // basic 8-bit frames, phase 0, polarity 0
        setcfg(4'b0000, 2, 2, 2, 3);
        push(16'h00A5, 8, 4'b0001, 0, 0, 0);
        push(16'h003C, 8, 4'b0001, 0, 0, 0);
        drain();

        tag = "R5";   // phase 1 bit order
        push(16'h00C3, 8, 4'b0100, 0, 1, 0);
        push(16'h005A, 8, 4'b0100, 0, 1, 0);
        drain();

        tag = "R4";   // polarity 1, both phases
        push(16'h0096, 8, 4'b0010, 0, 0, 1);
        push(16'h0069, 8, 4'b0010, 0, 1, 1);
        drain();

        tag = "R3";   // 4-bit frames, longer half period and lead
        setcfg(4'b0000, 3, 4, 2, 2);
        push(16'h000B, 4, 4'b1000, 0, 0, 0);
        push(16'h0006, 4, 4'b1000, 0, 1, 1);
        drain();

        tag = "R9";   // held selects across three 4-bit frames
        setcfg(4'b0000, 2, 2, 2, 5);
        push(16'h0009, 4, 4'b0001, 1, 1, 0);
        push(16'h0005, 4, 4'b0001, 1, 1, 0);
        push(16'h000E, 4, 4'b0001, 0, 1, 1);
        drain();

        tag = "R10";  // hold with a different select, then hold with nothing queued
        push(16'h0033, 6, 4'b0001, 1, 0, 0);
        push(16'h0011, 6, 4'b0010, 0, 0, 0);
        drain();
        push(16'h0027, 6, 4'b0100, 1, 1, 0);
        drain();

        tag = "R11";  // zero settings act as one cycle
        setcfg(4'b0000, 0, 0, 0, 0);
        push(16'h00F0, 8, 4'b0011, 0, 0, 0);
        push(16'h0081, 8, 4'b0011, 1, 1, 0);
        push(16'h007E, 8, 4'b0011, 0, 0, 1);
        drain();

        tag = "R7";   // long release delay, held 16-bit pair
        setcfg(4'b0000, 1, 1, 5, 1);
        push(16'hBEEF, 16, 4'b1001, 1, 0, 0);
        push(16'h1234, 16, 4'b1001, 0, 1, 0);
        drain();

        tag = "R8";   // non-held frames with mixed idle levels
        setcfg(4'b1010, 2, 3, 1, 4);
        push(16'h0155, 10, 4'b0011, 0, 0, 0);
        push(16'h02AA, 10, 4'b0011, 0, 1, 1);
        push(16'h0077, 10, 4'b1100, 0, 0, 0);
        drain();

        tag = "R6";   // one-bit frames, both phases
        setcfg(4'b0000, 2, 1, 1, 1);
        push(16'h0001, 1, 4'b0001, 0, 0, 0);
        push(16'h0000, 1, 4'b0001, 1, 1, 0);
        push(16'h0001, 1, 4'b0001, 0, 1, 1);
        drain();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule